// File: doc/BRIEF.md
# Priority Transmit Descriptor Arbiter

This block sits between a transmit MAC and the regular transmit descriptor ring. It holds one software-owned priority descriptor: a 32-bit word with control bits, captured status bits and a 16-bit buffer length. Its main use is to send an urgent single-buffer frame, such as a flow-control frame, ahead of the queued ring traffic. Each time no frame is in flight, the block picks the next frame source. It starts the MAC with a one-cycle start strobe and a source select, waits for the MAC's done pulse, and then returns to the boundary state.

Software fills the descriptor while its ready bit is clear, then sets ready. From that point the word is locked. When the priority frame ends, whether cleanly or with an error, the block clears ready and stores the MAC's error flags in the word. If the descriptor asked for an interrupt, the block also raises a one-cycle completion event. While the MAC is in pause mode the priority descriptor loses its precedence and waits behind ring traffic.

Top module: `oos_txbd_arbiter`

## Requirements
- R1: A source is chosen only when no frame is in progress. `mac_start` pulses for one cycle in that boundary cycle and does not pulse again until `mac_done` has ended the frame. A running frame is never pre-empted.
- R2: If the priority descriptor is not ready at a boundary and `ring_req` is high, then in the same cycle `ring_grant` and `mac_start` are high and `mac_sel_prio` is low.
- R3: Bit 27 (last-in-frame) of `cfg_rdata` always reads 1, including after reset. Writes to bit 27 have no effect.
- R4: `txc_event` is high for exactly the one cycle after the `mac_done` that ends a priority frame, and only when that descriptor's interrupt bit (bit 28) was set. It never fires for ring frames.
- R5: The `mac_done` that ends a priority frame clears the ready bit (bit 31) in the next cycle. It also stores `mac_err[2]` (late collision) in bit 24, `mac_err[1]` (retry limit) in bit 23 and `mac_err[0]` (underrun) in bit 22.
- R6: While the ready bit is set, `cfg_we` has no effect on any bit of the descriptor.
- R7: While `pause_on` is high, a high `ring_req` wins at a boundary. The priority descriptor is started only when `ring_req` is low.
- R8: Outside pause, when the descriptor is ready at a boundary it wins over `ring_req`. Its length (bits 15:0) is presented on `mac_len` and its pad bit (bit 30) on `mac_pad`.
- R9: A write accepted while ready is clear loads ready (31), pad (30), wrap (29), interrupt (28) and length (15:0), and clears the status bits 24:22. Bits 26:25 and 21:16 read 0.
- R10: After reset, `cfg_rdata` reads 32'h0800_0000 and `mac_start`, `ring_grant` and `txc_event` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_wdata | input | 32 | Descriptor write data |
| cfg_rdata | output | 32 | Current descriptor word |
| ring_req | input | 1 | Regular ring has a frame waiting |
| ring_grant | output | 1 | Ring frame chosen this cycle |
| pause_on | input | 1 | MAC is in pause mode |
| mac_start | output | 1 | One-cycle frame start strobe |
| mac_sel_prio | output | 1 | Started frame comes from the priority descriptor |
| mac_len | output | 16 | Priority buffer length |
| mac_pad | output | 1 | Pad request for the priority frame |
| mac_done | input | 1 | One-cycle end-of-frame pulse |
| mac_err | input | 3 | Error flags valid with `mac_done` |
| txc_event | output | 1 | Priority frame completion event |

## Verification
A wrong frame-state register shows at the ports within one cycle: a second `mac_start` appears, or a start is missing at a boundary. A corrupted descriptor register shows directly on `cfg_rdata` after the next clock edge. A missed ready clear is visible later, because the same descriptor is started again at the following boundary. A lost interrupt bit shows up one cycle after the priority frame's done pulse, as a missing or extra `txc_event`.

// File: rtl/oos_txbd_pkg.sv
package oos_txbd_pkg;
  localparam int DATA_W   = 32;
  localparam int LEN_W    = 16;
  localparam int ERR_W    = 3;
  localparam int BIT_RDY  = DATA_W - 1;
  localparam int BIT_PAD  = DATA_W - 2;
  localparam int BIT_WRAP = DATA_W - 3;
  localparam int BIT_INTR = DATA_W - 4;
  localparam int BIT_LAST = DATA_W - 5;
  localparam int ERR_HI   = DATA_W - 8;
  localparam int ERR_LO   = ERR_HI - ERR_W + 1;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PRIO = 2'd1,
    SRC_RING = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRIO = 2'd1,
    ST_RING = 2'd2
  } fstate_e;
endpackage

// File: rtl/oos_desc_reg.sv
module oos_desc_reg
  import oos_txbd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LEN_W,
  parameter int EW = ERR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_en,
  input  logic [EW-1:0] err_in,
  output logic          rdy,
  output logic          pad,
  output logic          intr,
  output logic [LW-1:0] len,
  output logic [DW-1:0] rdata
);
  localparam int EHI = DW - 8;
  localparam int ELO = EHI - EW + 1;

  logic          rdy_q, rdy_d;
  logic          pad_q, pad_d;
  logic          wrap_q, wrap_d;
  logic          intr_q, intr_d;
  logic [EW-1:0] err_q, err_d;
  logic [LW-1:0] len_q, len_d;
  logic          wr_ok;
  logic          load_en;

  // Accepted only while software owns the descriptor.
  assign wr_ok   = wr_en && !rdy_q;
  assign load_en = clr_en || wr_ok;

  always_comb begin
    rdy_d  = rdy_q;
    pad_d  = pad_q;
    wrap_d = wrap_q;
    intr_d = intr_q;
    err_d  = err_q;
    len_d  = len_q;
    if (clr_en) begin
      rdy_d = 1'b0;
      err_d = err_in;
    end else if (wr_ok) begin
      rdy_d  = wr_data[DW-1];
      pad_d  = wr_data[DW-2];
      wrap_d = wr_data[DW-3];
      intr_d = wr_data[DW-4];
      err_d  = '0;
      len_d  = wr_data[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      pad_q  <= 1'b0;
      wrap_q <= 1'b0;
      intr_q <= 1'b0;
      err_q  <= '0;
      len_q  <= '0;
    end else if (load_en) begin
      rdy_q  <= rdy_d;
      pad_q  <= pad_d;
      wrap_q <= wrap_d;
      intr_q <= intr_d;
      err_q  <= err_d;
      len_q  <= len_d;
    end
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[DW-5:LW];

  always_comb begin
    rdata          = '0;
    rdata[DW-1]    = rdy_q;
    rdata[DW-2]    = pad_q;
    rdata[DW-3]    = wrap_q;
    rdata[DW-4]    = intr_q;
    rdata[DW-5]    = 1'b1;
    rdata[EHI:ELO] = err_q;
    rdata[LW-1:0]  = len_q;
  end

  assign rdy  = rdy_q;
  assign pad  = pad_q;
  assign intr = intr_q;
  assign len  = len_q;
endmodule

// File: rtl/oos_frame_arb.sv
module oos_frame_arb
  import oos_txbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic prio_rdy,
  input  logic ring_req,
  input  logic pause_on,
  input  logic mac_done,
  output logic mac_start,
  output logic sel_prio,
  output logic ring_grant,
  output logic prio_done
);
  fstate_e st_q, st_d;
  src_e    pick;

  // Pause demotes the priority descriptor behind ring traffic.
  always_comb begin
    pick = SRC_NONE;
    if (pause_on) begin
      if (ring_req)      pick = SRC_RING;
      else if (prio_rdy) pick = SRC_PRIO;
    end else begin
      if (prio_rdy)      pick = SRC_PRIO;
      else if (ring_req) pick = SRC_RING;
    end
  end

  always_comb begin
    st_d       = st_q;
    mac_start  = 1'b0;
    sel_prio   = 1'b0;
    ring_grant = 1'b0;
    prio_done  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (pick != SRC_NONE) begin
          mac_start  = 1'b1;
          sel_prio   = (pick == SRC_PRIO);
          ring_grant = (pick == SRC_RING);
          st_d       = (pick == SRC_PRIO) ? ST_PRIO : ST_RING;
        end
      end
      ST_PRIO: begin
        if (mac_done) begin
          prio_done = 1'b1;
          st_d      = ST_IDLE;
        end
      end
      ST_RING: begin
        if (mac_done) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/oos_evt_gen.sv
module oos_evt_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic prio_done,
  input  logic intr_en,
  output logic evt
);
  logic evt_q, evt_d;

  assign evt_d = prio_done && intr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign evt = evt_q;
endmodule

// File: rtl/oos_txbd_arbiter.sv
module oos_txbd_arbiter
  import oos_txbd_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int LW = LEN_W,
  parameter int EW = ERR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          ring_req,
  output logic          ring_grant,
  input  logic          pause_on,
  output logic          mac_start,
  output logic          mac_sel_prio,
  output logic [LW-1:0] mac_len,
  output logic          mac_pad,
  input  logic          mac_done,
  input  logic [EW-1:0] mac_err,
  output logic          txc_event
);
  logic prio_rdy;
  logic prio_intr;
  logic prio_done;

  oos_desc_reg #(.DW(DW), .LW(LW), .EW(EW)) u_desc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .clr_en  (prio_done),
    .err_in  (mac_err),
    .rdy     (prio_rdy),
    .pad     (mac_pad),
    .intr    (prio_intr),
    .len     (mac_len),
    .rdata   (cfg_rdata)
  );

  oos_frame_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .prio_rdy   (prio_rdy),
    .ring_req   (ring_req),
    .pause_on   (pause_on),
    .mac_done   (mac_done),
    .mac_start  (mac_start),
    .sel_prio   (mac_sel_prio),
    .ring_grant (ring_grant),
    .prio_done  (prio_done)
  );

  oos_evt_gen u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .prio_done (prio_done),
    .intr_en   (prio_intr),
    .evt       (txc_event)
  );
endmodule

// File: rtl/oos_txbd_arbiter_chk.sv
module oos_txbd_arbiter_chk
  import oos_txbd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              ring_req,
  input logic              ring_grant,
  input logic              pause_on,
  input logic              mac_start,
  input logic              mac_sel_prio,
  input logic              mac_done,
  input logic              txc_event
);
  // R1
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_start |=> !mac_start);

  // R2
  grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_grant |-> (mac_start && !mac_sel_prio));

  // R3
  last_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[BIT_LAST]);

  // R4
  event_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txc_event |-> $past(mac_done));

  // R5
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rdata[BIT_RDY]) |-> $past(mac_done));

  // R6
  locked_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_rdata[BIT_RDY]) && !$past(mac_done)) |-> $stable(cfg_rdata));

  // R7
  pause_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_start && mac_sel_prio && pause_on) |-> !ring_req);

  // R8
  prio_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_start && !pause_on && cfg_rdata[BIT_RDY]) |-> mac_sel_prio);
endmodule

bind oos_txbd_arbiter oos_txbd_arbiter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_rdata    (cfg_rdata),
  .ring_req     (ring_req),
  .ring_grant   (ring_grant),
  .pause_on     (pause_on),
  .mac_start    (mac_start),
  .mac_sel_prio (mac_sel_prio),
  .mac_done     (mac_done),
  .txc_event    (txc_event)
);

// File: tb/oos_txbd_arbiter_test.sv
module oos_txbd_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        ring_req;
  logic        ring_grant;
  logic        pause_on;
  logic        mac_start;
  logic        mac_sel_prio;
  logic [15:0] mac_len;
  logic        mac_pad;
  logic        mac_done;
  logic [2:0]  mac_err;
  logic        txc_event;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // Reference model state
  bit          m_busy, m_prio;
  logic        m_rdy, m_pad, m_wrap, m_intr, m_evt;
  logic [2:0]  m_err;
  logic [15:0] m_len;

  oos_txbd_arbiter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ring_req(ring_req), .ring_grant(ring_grant),
    .pause_on(pause_on), .mac_start(mac_start), .mac_sel_prio(mac_sel_prio),
    .mac_len(mac_len), .mac_pad(mac_pad), .mac_done(mac_done),
    .mac_err(mac_err), .txc_event(txc_event)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_word();
    return {m_rdy, m_pad, m_wrap, m_intr, 1'b1, 2'b00, m_err, 6'b0, m_len};
  endfunction

  // 0 none, 1 priority, 2 ring
  function automatic int exp_pick(logic rdy, logic pse, logic req);
    if (pse) return req ? 2 : (rdy ? 1 : 0);
    return rdy ? 1 : (req ? 2 : 0);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic step(logic we, logic [31:0] wd, logic req, logic pse,
                      logic done, logic [2:0] err);
    int    pk;
    bit    idle;
    logic  rdy_pre;
    string tag;
    cfg_we = we; cfg_wdata = wd; ring_req = req; pause_on = pse;
    mac_done = done; mac_err = err;
    #1;
    pk   = exp_pick(m_rdy, pse, req);
    idle = !m_busy;
    chk("R1", {31'b0, mac_start}, {31'b0, idle && pk != 0});
    chk("R2", {31'b0, ring_grant}, {31'b0, idle && pk == 2});
    if (idle && pk != 0)
      chk(pse ? "R7" : "R8", {31'b0, mac_sel_prio}, {31'b0, pk == 1});
    if (idle && pk == 1) begin
      chk("R8", {16'b0, mac_len}, {16'b0, m_len});
      chk("R8", {31'b0, mac_pad}, {31'b0, m_pad});
    end
    rdy_pre = m_rdy;
    tag = "R9";
    m_evt = 1'b0;
    if (m_busy && done) begin
      m_busy = 0;
      if (m_prio) begin
        m_rdy = 1'b0; m_err = err; m_evt = m_intr; tag = "R5";
      end
    end else if (idle && pk != 0) begin
      m_busy = 1; m_prio = (pk == 1);
    end
    if (we) begin
      if (rdy_pre) tag = "R6";
      else begin
        m_rdy = wd[31]; m_pad = wd[30]; m_wrap = wd[29]; m_intr = wd[28];
        m_len = wd[15:0]; m_err = 3'b0;
      end
    end
    @(posedge clk);
    #1;
    chk(tag, cfg_rdata, exp_word());
    chk("R3", {31'b0, cfg_rdata[27]}, 32'd1);
    chk("R4", {31'b0, txc_event}, {31'b0, m_evt});
    @(negedge clk);
  endtask

  task automatic idle_step(logic req, logic pse);
    step(1'b0, 32'h0, req, pse, 1'b0, 3'b0);
  endtask

  task automatic finish_frame(logic [2:0] err);
    step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = '0; ring_req = 0; pause_on = 0;
    mac_done = 0; mac_err = '0;
    m_busy = 0; m_prio = 0; m_rdy = 0; m_pad = 0; m_wrap = 0; m_intr = 0;
    m_err = '0; m_len = '0; m_evt = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", cfg_rdata, 32'h0800_0000);
    chk("R10", {29'b0, mac_start, ring_grant, txc_event}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", cfg_rdata, 32'h0800_0000);

    // R3/R9: write with last bit cleared, ready clear
    step(1'b1, 32'h6000_0040, 1'b0, 1'b0, 1'b0, 3'b0);
    chk("R3", {31'b0, cfg_rdata[27]}, 32'd1);
    // Arm priority descriptor with interrupt
    step(1'b1, 32'hD000_0020, 1'b0, 1'b0, 1'b0, 3'b0);
    // R8: both ready, priority wins
    idle_step(1'b1, 1'b0);
    // R6: write while ready is blocked
    step(1'b1, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 3'b0);
    // R1: no restart while in flight
    idle_step(1'b1, 1'b0);
    // R5/R4: done with errors, event fires
    finish_frame(3'b101);
    // R2: ring frame, no event on its done
    idle_step(1'b1, 1'b0);
    finish_frame(3'b111);
    // R7: pause with both ready, ring wins, then priority when ring idle
    step(1'b1, 32'h8000_0011, 1'b0, 1'b1, 1'b0, 3'b0);
    idle_step(1'b1, 1'b1);
    finish_frame(3'b000);
    idle_step(1'b0, 1'b1);
    finish_frame(3'b010);
    // R4: interrupt bit clear gives no event
    step(1'b1, 32'h8000_0005, 1'b0, 1'b0, 1'b0, 3'b0);
    idle_step(1'b0, 1'b0);
    finish_frame(3'b000);

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic        we, req, pse, dn;
      logic [31:0] wd;
      we  = ($urandom % 6) == 0;
      wd  = $urandom;
      req = ($urandom % 2) == 0;
      pse = ($urandom % 4) == 0;
      dn  = m_busy && (($urandom % 4) == 0);
      step(we, wd, req, pse, dn, 3'($urandom));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule